// File: doc/BRIEF.md
# UART Receive Byte Queue with Threshold Interrupt and Flow Control

This block sits between a UART's receive shifter and the host. Each character the shifter assembles arrives with its framing-error flag, and the block stores both in a queue. The host takes them out in arrival order. The queue has two capacities, 16 or 64 entries, chosen by a depth-mode bit. When buffering is switched off, the block acts as a single-byte holding register.

A 2-bit trigger code sets a fill threshold. The meaning of that threshold depends on the depth mode. The same threshold does two jobs. It raises the interrupt request, and it withdraws the ready-to-send permission (RTS) given to the remote transmitter. RTS is granted again only once the queue has drained completely.

A character timer catches a small number of characters left waiting below the threshold. It counts character-time ticks and raises a time-out indication once a set number of ticks pass with no write and no host read.

The write side is a valid/ready stream, but the shifter cannot stall, so `in_ready` is advisory only. If a character is offered while `in_ready` is low, it is discarded and an overrun pulse is raised. On the read side, `out_valid` means at least one entry is stored. A transfer happens on any cycle where `out_valid` and `out_ready` are both high. The dequeued byte appears on `out_data` in the following cycle and stays there until the next transfer. A read strobe on an empty queue moves nothing.

Top module: `rx_fifo_fc`

## Requirements
- R1: After reset, the block reports empty: `level` is 0 and `out_valid` is 0. It also shows `in_ready`=1, `rts`=1, `irq`=0 and `timeout`=0.
- R2: Entries leave in the same order they arrived. For each transfer, `out_data` and `out_ferr` carry the stored character and its framing flag one cycle after the transfer.
- R3: In 16-entry mode (`depth64`=0), trigger codes 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14. `irq` is high whenever `level` is at or above the threshold.
- R4: In 64-entry mode (`depth64`=1), trigger codes 0, 1, 2 and 3 give thresholds of 1, 16, 32 and 56, with the same `irq` rule as R3.
- R5: Capacity is 16 entries in 16-entry mode and 64 in 64-entry mode, and `in_ready` is 0 when the queue is full. A character offered while full is dropped, `level` does not change, and `overrun` is high for exactly the next cycle.
- R6: A read strobe while the queue is empty leaves `level` at 0 and leaves `out_data` holding its last value.
- R7: `rts` goes to 0 one cycle after `level` reaches the threshold. It stays 0 as `level` falls, and returns to 1 one cycle after `level` reaches 0.
- R8: With the queue non-empty, `timeout` rises after 4 `char_tick` pulses with no write or read in between. Any write or read strobe clears it and restarts the count. It is never set while the queue is empty, and it also drives `irq`.
- R9: With `fifo_en`=0, the block holds a single byte. `irq` is high while that byte is held, and `rts` drops one cycle after the byte is loaded. A second byte offered while one is held is dropped with an `overrun` pulse.
- R10: A `fifo_clr` pulse empties the queue. In the next cycle `level` is 0, `rts` is 1, and `timeout` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = queue buffering, 0 = single holding byte |
| depth64 | input | 1 | 1 = 64-entry mode, 0 = 16-entry mode |
| trig_sel | input | 2 | Trigger threshold code |
| fifo_clr | input | 1 | Synchronous queue clear |
| char_tick | input | 1 | One pulse per character time |
| in_valid | input | 1 | Character offered by the receive shifter |
| in_data | input | 8 | Received character |
| in_ferr | input | 1 | Framing error flag of the character |
| in_ready | output | 1 | Space available (advisory) |
| out_valid | output | 1 | Queue not empty |
| out_ready | input | 1 | Host read strobe |
| out_data | output | 8 | Last dequeued character |
| out_ferr | output | 1 | Framing flag of the last dequeued character |
| overrun | output | 1 | One-cycle pulse for a dropped character |
| level | output | 7 | Number of stored entries |
| irq | output | 1 | Threshold or time-out interrupt request |
| timeout | output | 1 | Character time-out indication |
| rts | output | 1 | 1 = remote transmitter may send |

## Verification
A wrong stored count shows up right away on `level` and `irq`, and one cycle later on `rts`. A wrapped or misplaced pointer shows up as a wrong character or wrong framing flag on the first transfer after the damaged write. A stale timer shows up on `timeout` within four ticks: it either fires early after activity, or stays silent while characters sit in the queue. Threshold decoding is checked at exactly count-1 and count for every code in both depth modes, so a threshold that is off by one entry is caught.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    TRIG_ONE  = 2'd0,
    TRIG_QTR  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_NEAR = 2'd3
  } trig_sel_e;

  // Threshold for a queue of `size` entries: 1, size/4, size/2, size - size/8
  function automatic int unsigned trig_threshold(int unsigned size, logic [1:0] code);
    case (trig_sel_e'(code))
      TRIG_ONE:  return 1;
      TRIG_QTR:  return size / 4;
      TRIG_HALF: return size / 2;
      default:   return size - size / 8;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int PW     = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic            pop,
  input  logic [CW-1:0]   cap,
  input  logic [DATA_W:0] din,
  output logic [DATA_W:0] dout,
  output logic [CW-1:0]   count
);
  logic [DATA_W:0] mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    if (CW'(p) + CW'(1) >= cap) return '0;
    return p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= adv(wptr);
      if (pop) begin
        rptr <= adv(rptr);
        dout <= mem[rptr];
      end
      count <= count + CW'(push) - CW'(pop);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push) |=> (count == '0 || $past(clr))) else $error("count underflow"); // R6
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TO_CHARS = 4,
  parameter int TW       = $clog2(TO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic activity,
  input  logic nonempty,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks   <= '0;
      expired <= 1'b0;
    end else if (clr || activity || !nonempty) begin
      ticks   <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      if (ticks == TW'(TO_CHARS - 1)) begin
        expired <= 1'b1;
        ticks   <= '0;
      end else begin
        ticks <= ticks + TW'(1);
      end
    end
  end

  AST_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty |=> !expired) else $error("time-out while empty"); // R8
  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !expired) else $error("time-out survived activity"); // R8
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  input  logic          to_flag,
  output logic          irq,
  output logic          rts
);
  logic at_trigger;
  assign at_trigger = (count >= thr);
  assign irq        = at_trigger || to_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rts <= 1'b1;
    else if (clr)              rts <= 1'b1;
    else if (at_trigger)       rts <= 1'b0;
    else if (count == '0)      rts <= 1'b1;
  end

  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count >= thr) |=> !rts) else $error("rts not withdrawn"); // R7
  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !rts && count != '0) |=> !rts) else $error("rts regranted early"); // R7
endmodule

// File: rtl/rx_fifo_fc.sv
module rx_fifo_fc #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 64,
  parameter int TO_CHARS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_en,
  input  logic                         depth64,
  input  logic [1:0]                   trig_sel,
  input  logic                         fifo_clr,
  input  logic                         char_tick,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_data,
  input  logic                         in_ferr,
  output logic                         in_ready,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_ferr,
  output logic                         overrun,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         irq,
  output logic                         timeout,
  output logic                         rts
);
  import rxq_pkg::*;

  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(DEPTH);
  localparam int SMALL = DEPTH / 4;

  logic [CW-1:0]   cap, thr;
  logic            push, pop;
  logic [DATA_W:0] head;

  always_comb begin
    if (!fifo_en) begin
      cap = CW'(1);
      thr = CW'(1);
    end else if (depth64) begin
      cap = CW'(DEPTH);
      thr = CW'(trig_threshold(DEPTH, trig_sel));
    end else begin
      cap = CW'(SMALL);
      thr = CW'(trig_threshold(SMALL, trig_sel));
    end
  end

  assign in_ready  = (level < cap);
  assign out_valid = (level != '0);
  assign push      = in_valid && in_ready && !fifo_clr;
  assign pop       = out_ready && out_valid && !fifo_clr;
  assign out_data  = head[DATA_W-1:0];
  assign out_ferr  = head[DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= in_valid && !in_ready && !fifo_clr;
  end

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .pop(pop),
    .cap(cap), .din({in_ferr, in_data}), .dout(head), .count(level)
  );

  rxq_timeout #(.TO_CHARS(TO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .activity(in_valid || out_ready), .nonempty(out_valid),
    .tick(char_tick), .expired(timeout)
  );

  rxq_flow #(.CW(CW)) u_flow (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .count(level), .thr(thr),
    .to_flag(timeout), .irq(irq), .rts(rts)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= CW'(DEPTH))) else $error("level above depth"); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fifo_clr && !out_ready && level == cap) |=> (overrun && $stable(level)))
    else $error("full write not dropped"); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && level == '0 && !in_valid && !fifo_clr) |=> (level == '0 && $stable(out_data)))
    else $error("empty read moved state"); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (level == '0 && rts && !timeout)) else $error("clear incomplete"); // R10
endmodule

// File: tb/rx_fifo_fc_tb.sv
module rx_fifo_fc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, depth64 = 1'b0, fifo_clr = 1'b0, char_tick = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic       in_valid = 1'b0, in_ferr = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_ferr, overrun, irq, timeout, rts;
  logic [7:0] out_data;
  logic [6:0] level;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] sb[$];
  logic pop_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_fc u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .depth64(depth64), .trig_sel(trig_sel),
    .fifo_clr(fifo_clr), .char_tick(char_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ferr(in_ferr), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ferr(out_ferr), .overrun(overrun), .level(level),
    .irq(irq), .timeout(timeout), .rts(rts)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every observed transfer pops the scoreboard and compares (R2)
  always @(posedge clk) pop_d <= rst_n && out_ready && out_valid && !fifo_clr;
  always @(negedge clk) begin
    if (pop_d) begin
      if (sb.size() == 0) chk(1'b0, "R2 unexpected transfer", {23'd0, out_ferr, out_data}, -1);
      else begin
        logic [8:0] e;
        e = sb.pop_front();
        chk({out_ferr, out_data} == e, "R2 order/data", {23'd0, out_ferr, out_data}, {23'd0, e});
      end
    end
  end

  task automatic wr(input logic [7:0] d, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ferr = f;
    if (in_ready) sb.push_back({f, d});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1'b1;
    @(negedge clk); char_tick = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); fifo_clr = 1'b1; sb.delete();
    @(negedge clk); fifo_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int thr_of(input bit big, input int code);
    int s;
    s = big ? 64 : 16;
    case (code)
      0: return 1;
      1: return s / 4;
      2: return s / 2;
      default: return s - s / 8;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(level == 0 && !out_valid, "R1 empty", level, 0);
    chk(in_ready && rts && !irq && !timeout, "R1 flags", {in_ready, rts, irq, timeout}, 4'b1100);

    // Basic 16-entry flow with threshold 4
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) wr(8'h10 + 8'(i), i[0]);
    idle(1);
    chk(!irq && rts, "R3 below threshold", {irq, rts}, 2'b01);
    wr(8'h13, 1'b1);
    chk(irq, "R3 at threshold", irq, 1);
    idle(1);
    chk(!rts, "R7 rts drop", rts, 0);
    rd(); idle(1);
    chk(!irq && !rts, "R7 rts held below threshold", {irq, rts}, 2'b00);
    for (int i = 0; i < 3; i++) rd();
    idle(1);
    chk(rts && level == 0, "R7 rts regranted on empty", {rts, 1'b0}, 2'b10);
    // R6 empty read
    rd(); idle(1);
    chk(out_data == 8'h13 && out_ferr && level == 0, "R6 empty read", out_data, 8'h13);

    // R3/R4 threshold sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        int t;
        depth64 = m[0]; trig_sel = c[1:0];
        clr();
        t = thr_of(m[0], c);
        for (int i = 0; i < t - 1; i++) wr(8'(i * 3 + c), 1'b0);
        idle(1);
        chk(!irq, m ? "R4 below threshold" : "R3 below threshold", irq, 0);
        wr(8'hA0, 1'b0);
        chk(irq, m ? "R4 at threshold" : "R3 at threshold", irq, 1);
        idle(1);
        chk(!rts, "R7 rts at threshold", rts, 0);
      end
    end

    // R5 capacity 16 and overrun
    depth64 = 1'b0; trig_sel = 2'd3;
    clr();
    for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i), i[1]);
    chk(level == 16 && !in_ready, "R5 full at 16", level, 16);
    wr(8'hEE, 1'b1);
    chk(overrun && level == 16, "R5 overrun pulse", {overrun, level}, {1'b1, 7'd16});
    idle(1);
    chk(!overrun, "R5 overrun one cycle", overrun, 0);
    for (int i = 0; i < 16; i++) rd();
    idle(1);
    chk(sb.size() == 0 && level == 0, "R2 all drained", sb.size(), 0);

    // R5 capacity 64
    depth64 = 1'b1;
    clr();
    for (int i = 0; i < 64; i++) wr(8'(i), 1'b0);
    chk(level == 64 && !in_ready, "R5 full at 64", level, 64);
    clr();
    chk(level == 0 && rts && !irq && !timeout, "R10 clear", level, 0);

    // R8 time-out
    depth64 = 1'b0; trig_sel = 2'd3;
    for (int i = 0; i < 4; i++) tick();
    chk(!timeout, "R8 no time-out when empty", timeout, 0);
    wr(8'h77, 1'b0); wr(8'h78, 1'b1);
    for (int i = 0; i < 3; i++) tick();
    chk(!timeout && !irq, "R8 before expiry", timeout, 0);
    tick();
    chk(timeout && irq, "R8 expiry", {timeout, irq}, 2'b11);
    rd();
    chk(!timeout, "R8 cleared by read", timeout, 0);
    for (int i = 0; i < 3; i++) tick();
    wr(8'h79, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    chk(!timeout, "R8 restart on write", timeout, 0);
    tick();
    chk(timeout, "R8 expiry after restart", timeout, 1);
    // R10 clear with data and time-out pending
    clr();
    chk(level == 0 && rts && !irq && !timeout, "R10 clear pending", {level, irq, timeout}, 0);

    // R9 holding-register mode
    fifo_en = 1'b0;
    clr();
    wr(8'h5A, 1'b1);
    chk(irq && level == 1, "R9 irq on held byte", {irq, level}, {1'b1, 7'd1});
    idle(1);
    chk(!rts, "R9 rts follows held byte", rts, 0);
    wr(8'h11, 1'b0);
    chk(overrun && level == 1, "R9 second byte dropped", {overrun, level}, {1'b1, 7'd1});
    rd(); idle(1);
    chk(!irq && rts && level == 0, "R9 released", {irq, rts}, 2'b01);

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule